// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is a single-lane SPI flash master. Software programs it through a byte-wide register port and a separate 256-byte data buffer port. For each start request it runs one complete flash command. The frame is built from four pieces, in this order: an opcode byte, a per-command number of address bytes, a run of idle dummy clocks, and a data phase. In the data phase, write bytes are taken from the buffer; read bytes are captured into the same buffer.

The engine runs only in manual mode. After reset the block is in direct mode. Software enters manual mode by writing two unlock bytes to the opcode register and then clearing the mode field of the control byte. While a command runs, a busy flag stays high. When chip select is released, a completion flag is raised and stays set until software clears it.

The serial clock idles low (SPI mode 0). Its period is a fixed number of system clocks. One of two active-low chip selects is chosen per command.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset, the control byte (offset 0x4) reads 0x30 (direct mode, not busy, no start), the status byte (offset 0xC) reads 0x00, both chip selects are high and SCK is low.
- R2: Writing the control byte with bits 5:4 = 11 selects direct mode. Writing it with bits 5:4 = 00 selects manual mode only if the last two opcode-register (0x5) writes were 0x55 and then 0xAA; otherwise the mode is left unchanged. In direct mode a start request is ignored. Control bits 5:4 read 11 in direct mode and 00 in manual mode.
- R3: In manual mode with busy low, writing control bit 0 = 1 starts a command. Bit 0 reads 1 in the cycle after that write and 0 afterwards. Busy (bit 1) reads 1 from the cycle after the write until chip select is released. A start written while busy is ignored.
- R4: The frame is sent in this order, each byte MSB first: the opcode; then N address bytes; then D dummy SCK cycles with MOSI low; then the data phase. N is taken from configuration bits 18:16 and clamped to 4. The address bytes are the low N bytes of the 32-bit address register, most significant first. The address register is stored little-endian at offsets 0x8..0xB. D is taken from configuration bits 23:19. The configuration word is stored little-endian at offsets 0x0..0x3.
- R5: With control bit 3 = 1 (write), the data phase sends buffer bytes from index 0 upward. The byte count is the 16-bit value at offsets 0x6 (low) and 0x7 (high), clamped to 256.
- R6: With control bit 3 = 0 (read), MOSI is low during the data phase. MISO is sampled on rising SCK edges, MSB first, and the bytes are stored into the buffer from index 0 upward.
- R7: A byte count of 0 omits the data phase, and chip select is released after the last address or dummy clock.
- R8: Configuration bit 24 = 1 drives cs_no[1] low, and 0 drives cs_no[0] low. At most one chip select is ever low.
- R9: SCK idles low. MOSI is stable while SCK is high. The SCK period is 2*HALF_DIV clocks. Chip select falls HALF_DIV clocks before the first rising SCK edge and rises HALF_DIV clocks after the last falling edge.
- R10: Status bit 0 (offset 0xC) is set when a command completes and is cleared by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register byte write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 8 | Register write byte |
| reg_rdata_o | output | 8 | Register read byte at reg_addr_i |
| buf_we_i | input | 1 | Data buffer write strobe |
| buf_addr_i | input | AW | Data buffer index |
| buf_wdata_i | input | 8 | Data buffer write byte |
| buf_rdata_o | output | 8 | Data buffer byte at buf_addr_i |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |
| cs_no | output | 2 | Chip selects, active low |

## Verification
The bench targets these corner cases:
- A wrong unlock order, or a missing unlock. A design that ignores the unlock sequence would leave direct mode and run commands it should refuse.
- A start rewritten while busy. A design that accepts it would restart the frame and send bits the scoreboard never queued.
- An address count above four, a data count above the buffer size, a zero data count, and a dummy run between address and read data. Each of these, if mishandled, shows up as a missing, extra or shifted MOSI bit, or as a wrong byte read back from the buffer.
- The chip select to SCK margins and the SCK period are measured on every edge, so an off-by-one in the half-period counter is reported.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_HOLD} eng_st_e;
  typedef enum logic [1:0] {PH_OPC, PH_ADR, PH_DMY, PH_DAT} phase_e;

  localparam logic [3:0] OFS_CTRL = 4'h4;
  localparam logic [3:0] OFS_OPC  = 4'h5;
  localparam logic [3:0] OFS_STAT = 4'hC;

  typedef struct packed {
    logic        cs_sel;
    logic [2:0]  adr_bytes;
    logic [4:0]  dummy;
    logic        dir_wr;
    logic [7:0]  opcode;
    logic [31:0] addr;
    logic [15:0] count;
  } cmd_t;
endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       busy_i,
  input  logic       done_i,
  output logic       start_o,
  output logic       manual_o,
  output logic       irq_o,
  output cmd_t       cmd_o
);
  logic [3:0][7:0] cfg_q;
  logic [1:0][7:0] cnt_q;
  logic [3:0][7:0] adr_q;
  logic [7:0]      op_q, op_prev_q;
  logic            dir_q, manual_q, start_q, irq_q;
  logic            ctrl_wr, unlocked;

  assign ctrl_wr  = we_i && (addr_i == OFS_CTRL);
  assign unlocked = (op_prev_q == 8'h55) && (op_q == 8'hAA);
  assign start_o  = ctrl_wr && wdata_i[0] && !busy_i && manual_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      cnt_q     <= '0;
      adr_q     <= '0;
      op_q      <= '0;
      op_prev_q <= '0;
      dir_q     <= 1'b0;
      manual_q  <= 1'b0;
      start_q   <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      start_q <= start_o;
      if (we_i) begin
        unique case (addr_i)
          4'h0, 4'h1, 4'h2, 4'h3: cfg_q[addr_i[1:0]] <= wdata_i;
          OFS_CTRL: begin
            dir_q <= wdata_i[3];
            if (wdata_i[5:4] == 2'b11) manual_q <= 1'b0;
            else if (wdata_i[5:4] == 2'b00 && unlocked) manual_q <= 1'b1;
          end
          OFS_OPC: begin
            op_prev_q <= op_q;
            op_q      <= wdata_i;
          end
          4'h6, 4'h7: cnt_q[addr_i[0]] <= wdata_i;
          4'h8, 4'h9, 4'hA, 4'hB: adr_q[addr_i[1:0]] <= wdata_i;
          OFS_STAT: if (wdata_i[0]) irq_q <= 1'b0;
          default: ;
        endcase
      end
      if (done_i) irq_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr_i)
      4'h0, 4'h1, 4'h2, 4'h3: rdata_o = cfg_q[addr_i[1:0]];
      OFS_CTRL: rdata_o = {2'b00, {2{!manual_q}}, dir_q, 1'b0, busy_i, start_q};
      OFS_OPC:  rdata_o = op_q;
      4'h6, 4'h7: rdata_o = cnt_q[addr_i[0]];
      4'h8, 4'h9, 4'hA, 4'hB: rdata_o = adr_q[addr_i[1:0]];
      OFS_STAT: rdata_o = {7'd0, irq_q};
      default:  rdata_o = 8'h00;
    endcase
  end

  assign manual_o = manual_q;
  assign irq_o    = irq_q;
  assign cmd_o    = '{cs_sel:    cfg_q[3][0],
                      adr_bytes: cfg_q[2][2:0],
                      dummy:     cfg_q[2][7:3],
                      dir_wr:    dir_q,
                      opcode:    op_q,
                      addr:      adr_q,
                      count:     cnt_q};
endmodule

// File: rtl/spi_seq_dbuf.sv
module spi_seq_dbuf #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          hwe_i,
  input  logic [AW-1:0] haddr_i,
  input  logic [7:0]    hwdata_i,
  output logic [7:0]    hrdata_o,
  input  logic          ewe_i,
  input  logic [AW-1:0] ewaddr_i,
  input  logic [7:0]    ewdata_i,
  input  logic [AW-1:0] eraddr_i,
  output logic [7:0]    erdata_o
);
  logic [7:0] mem_q [DEPTH];

  // engine capture wins a same-cycle collision
  always_ff @(posedge clk_i) begin
    if (ewe_i)      mem_q[ewaddr_i] <= ewdata_i;
    else if (hwe_i) mem_q[haddr_i]  <= hwdata_i;
  end

  assign hrdata_o = mem_q[haddr_i];
  assign erdata_o = mem_q[eraddr_i];
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int unsigned BUF_DEPTH  = 256,
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned ADDR_BYTES = 4,
  localparam int unsigned AW = $clog2(BUF_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  cmd_t          cmd_i,
  output logic [AW-1:0] buf_raddr_o,
  input  logic [7:0]    buf_rdata_i,
  output logic          buf_we_o,
  output logic [AW-1:0] buf_waddr_o,
  output logic [7:0]    buf_wdata_o,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic [1:0]    cs_no,
  output logic          busy_o,
  output logic          done_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned NW = $clog2(BUF_DEPTH + 1);
  localparam int unsigned LW = NW + 3;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);
  localparam logic [2:0]    NA_MAX   = 3'(ADDR_BYTES);

  eng_st_e          st_q;
  phase_e           ph_q, nxt_ph, ld_ph;
  logic [CW-1:0]    cnt_q;
  logic [LW-1:0]    left_q;
  logic [2:0]       bit_q;
  logic [NW-1:0]    idx_q, ld_idx, nd_eff;
  logic [7:0]       sh_q, rx_q, ld_byte;
  logic             cs_q, nxt_ok, last_edge, ph_end;
  logic [2:0]       na_eff;
  logic [LW-1:0]    len [4];

  assign na_eff = (cmd_i.adr_bytes > NA_MAX) ? NA_MAX : cmd_i.adr_bytes;
  assign nd_eff = (cmd_i.count > 16'(BUF_DEPTH)) ? NW'(BUF_DEPTH) : NW'(cmd_i.count);

  assign len[0] = LW'(8);
  assign len[1] = LW'({na_eff, 3'b000});
  assign len[2] = LW'(cmd_i.dummy);
  assign len[3] = {nd_eff, 3'b000};

  // first non-empty phase after the current one
  always_comb begin
    nxt_ok = 1'b0;
    nxt_ph = PH_DAT;
    for (int k = 3; k >= 1; k--) begin
      if (k > int'(ph_q) && len[k] != '0) begin
        nxt_ok = 1'b1;
        nxt_ph = phase_e'(k);
      end
    end
  end

  assign last_edge = (cnt_q == CNT_LAST);
  assign ph_end    = (st_q == ST_HIGH) && last_edge && (left_q == LW'(1));

  always_comb begin
    int sh;
    if (st_q == ST_IDLE) begin
      ld_ph  = PH_OPC;
      ld_idx = '0;
    end else if (ph_end) begin
      ld_ph  = nxt_ph;
      ld_idx = '0;
    end else begin
      ld_ph  = ph_q;
      ld_idx = idx_q + NW'(1);
    end
    sh = int'(na_eff) - 1 - int'(ld_idx);
    unique case (ld_ph)
      PH_OPC:  ld_byte = cmd_i.opcode;
      PH_ADR:  ld_byte = (sh >= 0) ? 8'(cmd_i.addr >> (8 * sh)) : 8'h00;
      PH_DMY:  ld_byte = 8'h00;
      default: ld_byte = cmd_i.dir_wr ? buf_rdata_i : 8'h00;
    endcase
  end

  assign buf_raddr_o = ld_idx[AW-1:0];
  assign buf_we_o    = (st_q == ST_HIGH) && last_edge && (ph_q == PH_DAT) &&
                       !cmd_i.dir_wr && (bit_q == 3'd7);
  assign buf_waddr_o = idx_q[AW-1:0];
  assign buf_wdata_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_OPC;
      cnt_q  <= '0;
      left_q <= '0;
      bit_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      cs_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_LOW;
          cs_q   <= cmd_i.cs_sel;
          ph_q   <= PH_OPC;
          left_q <= len[0];
          bit_q  <= '0;
          idx_q  <= '0;
          sh_q   <= ld_byte;
          cnt_q  <= '0;
        end
        ST_LOW: begin
          if (last_edge) begin
            cnt_q <= '0;
            st_q  <= ST_HIGH;
            rx_q  <= {rx_q[6:0], miso_i};
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_HIGH: begin
          if (last_edge) begin
            cnt_q <= '0;
            if (left_q == LW'(1)) begin
              if (nxt_ok) begin
                st_q   <= ST_LOW;
                ph_q   <= nxt_ph;
                left_q <= len[nxt_ph];
                bit_q  <= '0;
                idx_q  <= '0;
                sh_q   <= ld_byte;
              end else st_q <= ST_HOLD;
            end else begin
              st_q   <= ST_LOW;
              left_q <= left_q - LW'(1);
              if (bit_q == 3'd7) begin
                bit_q <= '0;
                idx_q <= ld_idx;
                sh_q  <= ld_byte;
              end else begin
                bit_q <= bit_q + 3'd1;
                sh_q  <= {sh_q[6:0], 1'b0};
              end
            end
          end else cnt_q <= cnt_q + CW'(1);
        end
        default: begin
          if (last_edge) begin
            cnt_q <= '0;
            st_q  <= ST_IDLE;
          end else cnt_q <= cnt_q + CW'(1);
        end
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_HOLD) && last_edge;
  assign sck_o  = (st_q == ST_HIGH);
  assign mosi_o = busy_o && (ph_q != PH_DMY) && !(ph_q == PH_DAT && !cmd_i.dir_wr) && sh_q[7];
  assign cs_no  = !busy_o ? 2'b11 : (cs_q ? 2'b01 : 2'b10);
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int unsigned BUF_DEPTH  = 256,
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned ADDR_BYTES = 4,
  localparam int unsigned AW = $clog2(BUF_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          buf_we_i,
  input  logic [AW-1:0] buf_addr_i,
  input  logic [7:0]    buf_wdata_i,
  output logic [7:0]    buf_rdata_o,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic [1:0]    cs_no
);
  cmd_t          cmd_w;
  logic          start_w, busy_w, done_w, manual_w, irq_w;
  logic          ewe_w;
  logic [AW-1:0] ewaddr_w, eraddr_w;
  logic [7:0]    ewdata_w, erdata_w;

  spi_seq_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .busy_i   (busy_w),
    .done_i   (done_w),
    .start_o  (start_w),
    .manual_o (manual_w),
    .irq_o    (irq_w),
    .cmd_o    (cmd_w)
  );

  spi_seq_dbuf #(.DEPTH(BUF_DEPTH)) u_dbuf (
    .clk_i    (clk_i),
    .hwe_i    (buf_we_i),
    .haddr_i  (buf_addr_i),
    .hwdata_i (buf_wdata_i),
    .hrdata_o (buf_rdata_o),
    .ewe_i    (ewe_w),
    .ewaddr_i (ewaddr_w),
    .ewdata_i (ewdata_w),
    .eraddr_i (eraddr_w),
    .erdata_o (erdata_w)
  );

  spi_seq_engine #(
    .BUF_DEPTH  (BUF_DEPTH),
    .HALF_DIV   (HALF_DIV),
    .ADDR_BYTES (ADDR_BYTES)
  ) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_w),
    .cmd_i       (cmd_w),
    .buf_raddr_o (eraddr_w),
    .buf_rdata_i (erdata_w),
    .buf_we_o    (ewe_w),
    .buf_waddr_o (ewaddr_w),
    .buf_wdata_o (ewdata_w),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .miso_i      (miso_i),
    .cs_no       (cs_no),
    .busy_o      (busy_w),
    .done_o      (done_w)
  );
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sck_o,
  input logic       mosi_o,
  input logic [1:0] cs_no,
  input logic       busy_i,
  input logic       manual_i,
  input logic       irq_i
);
  a_r8_one_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  a_r9_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no == 2'b11) |-> !sck_o);

  a_r9_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  a_r10_flag_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> irq_i);

  a_r2_direct_no_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!manual_i && !busy_i) |=> !busy_i);

  a_r3_busy_holds_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (cs_no != 2'b11));
endmodule

bind spi_cmd_seq spi_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sck_o    (sck_o),
  .mosi_o   (mosi_o),
  .cs_no    (cs_no),
  .busy_i   (busy_w),
  .manual_i (manual_w),
  .irq_i    (irq_w)
);

// File: tb/spi_cmd_seq_test.sv
module spi_cmd_seq_test;
  localparam int HALF  = 2;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       buf_we = 1'b0;
  logic [7:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_rdata;
  logic       sck, mosi;
  logic       miso = 1'b0;
  logic [1:0] cs_n;

  always #10 clk = ~clk;

  spi_cmd_seq #(.BUF_DEPTH(DEPTH), .HALF_DIV(HALF), .ADDR_BYTES(4)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .buf_we_i(buf_we), .buf_addr_i(buf_addr), .buf_wdata_i(buf_wdata), .buf_rdata_o(buf_rdata),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  int   n_chk = 0, n_fail = 0, cyc = 0, txn = 0;
  bit   exp_bits[$];
  bit   miso_bits[$];
  logic [1:0] exp_cs = 2'b11;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_mosi(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) exp_bits.push_back(b[i]);
  endtask

  task automatic push_miso(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) miso_bits.push_back(b[i]);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // samples in the current low phase, no wait
  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic bwr(input int i, input logic [7:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_addr = 8'(i); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic brd(input int i, output logic [7:0] d);
    @(negedge clk);
    buf_addr = 8'(i);
    #1 d = buf_rdata;
  endtask

  task automatic setup_cmd(input bit cs, input int na, input int dmy, input logic [7:0] opc,
                           input logic [31:0] adr, input logic [15:0] cnt);
    wr(4'h2, {5'(dmy), 3'(na)});
    wr(4'h3, {7'd0, cs});
    wr(4'h5, opc);
    wr(4'h6, cnt[7:0]);
    wr(4'h7, cnt[15:8]);
    wr(4'h8, adr[7:0]);
    wr(4'h9, adr[15:8]);
    wr(4'hA, adr[23:16]);
    wr(4'hB, adr[31:24]);
    exp_cs = cs ? 2'b01 : 2'b10;
  endtask

  task automatic wait_txn(input int t0);
    while (txn == t0) @(negedge clk);
  endtask

  // scoreboard monitor and slave model
  initial begin
    logic       psck;
    logic [1:0] pcs;
    int         cs_fall, last_rise, last_fall;
    bit         first;
    psck = 1'b0; pcs = 2'b11; cs_fall = 0; last_rise = 0; last_fall = 0; first = 1'b0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      if (pcs == 2'b11 && cs_n != 2'b11) begin
        cs_fall = cyc; first = 1'b1;
        chk("R8 cs select", cs_n, exp_cs);
        miso = (miso_bits.size() > 0) ? miso_bits.pop_front() : 1'b0;
      end
      if (!psck && sck) begin
        if (first) chk("R9 cs setup", cyc - cs_fall, HALF);
        else       chk("R9 sck period", cyc - last_rise, 2 * HALF);
        first = 1'b0;
        last_rise = cyc;
        if (exp_bits.size() == 0) chk("R3 unexpected bit", 1, 0);
        else chk("R4 mosi bit", mosi, exp_bits.pop_front());
      end
      if (psck && !sck) begin
        last_fall = cyc;
        miso = (miso_bits.size() > 0) ? miso_bits.pop_front() : 1'b0;
      end
      if (pcs != 2'b11 && cs_n == 2'b11) begin
        chk("R9 cs hold", cyc - last_fall, HALF);
        chk("R3 bits left", exp_bits.size(), 0);
        txn++;
      end
      psck = sck; pcs = cs_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h4, d); chk("R1 ctrl reset", d, 8'h30);
    rd(4'hC, d); chk("R1 status reset", d, 8'h00);
    chk("R1 cs idle", cs_n, 2'b11);
    chk("R1 sck idle", sck, 1'b0);

    // R2 no unlock, start ignored in direct mode
    wr(4'h4, 8'h00); rd(4'h4, d); chk("R2 no unlock stays direct", d, 8'h30);
    wr(4'h4, 8'h01); rd(4'h4, d); chk("R2 start ignored busy", d[1], 1'b0);
    repeat (10) @(negedge clk);
    chk("R2 start ignored cs", cs_n, 2'b11);
    chk("R2 start ignored txn", txn, 0);

    // R2 wrong order, then correct unlock
    wr(4'h5, 8'hAA); wr(4'h5, 8'h55); wr(4'h4, 8'h00);
    rd(4'h4, d); chk("R2 wrong order stays direct", d, 8'h30);
    wr(4'h5, 8'h55); wr(4'h5, 8'hAA); wr(4'h4, 8'h00);
    rd(4'h4, d); chk("R2 unlocked manual", d, 8'h00);

    // R4 R5 R8 write with 3 address bytes on cs0
    bwr(0, 8'hDE); bwr(1, 8'hAD); bwr(2, 8'hBE); bwr(3, 8'hEF);
    setup_cmd(1'b0, 3, 0, 8'h02, 32'h0012_3456, 16'd4);
    push_mosi(8'h02); push_mosi(8'h12); push_mosi(8'h34); push_mosi(8'h56);
    push_mosi(8'hDE); push_mosi(8'hAD); push_mosi(8'hBE); push_mosi(8'hEF);
    t0 = txn;
    wr(4'h4, 8'h09);
    rd(4'h4, d); chk("R3 start and busy read", d, 8'h0B);
    @(negedge clk);
    rd(4'h4, d); chk("R3 start self clears", d, 8'h0A);
    wr(4'h4, 8'h09); // ignored while busy
    wait_txn(t0);
    rd(4'h4, d); chk("R3 busy low after cs release", d[1], 1'b0);
    repeat (40) @(negedge clk);
    chk("R3 no restart", txn, t0 + 1);

    // R10 status
    rd(4'hC, d); chk("R10 done flag set", d, 8'h01);
    wr(4'hC, 8'h01);
    rd(4'hC, d); chk("R10 done flag cleared", d, 8'h00);

    // R6 R8 read without address on cs1
    setup_cmd(1'b1, 0, 0, 8'h9F, 32'h0, 16'd3);
    push_mosi(8'h9F); push_mosi(8'h00); push_mosi(8'h00); push_mosi(8'h00);
    push_miso(8'h00); push_miso(8'hEF); push_miso(8'h40); push_miso(8'h18);
    t0 = txn;
    wr(4'h4, 8'h01);
    wait_txn(t0);
    brd(0, d); chk("R6 read byte 0", d, 8'hEF);
    brd(1, d); chk("R6 read byte 1", d, 8'h40);
    brd(2, d); chk("R6 read byte 2", d, 8'h18);

    // R4 dummy clocks before read data
    setup_cmd(1'b0, 3, 8, 8'h0B, 32'h00AB_CDEF, 16'd2);
    push_mosi(8'h0B); push_mosi(8'hAB); push_mosi(8'hCD); push_mosi(8'hEF);
    push_mosi(8'h00); push_mosi(8'h00); push_mosi(8'h00);
    for (int i = 0; i < 5; i++) push_miso(8'h00);
    push_miso(8'hA5); push_miso(8'h3C);
    t0 = txn;
    wr(4'h4, 8'h01);
    wait_txn(t0);
    brd(0, d); chk("R4 read after dummy byte 0", d, 8'hA5);
    brd(1, d); chk("R4 read after dummy byte 1", d, 8'h3C);

    // R7 zero count, R4 address count clamped to 4
    setup_cmd(1'b1, 6, 0, 8'h20, 32'h89AB_CDEF, 16'd0);
    push_mosi(8'h20); push_mosi(8'h89); push_mosi(8'hAB); push_mosi(8'hCD); push_mosi(8'hEF);
    t0 = txn;
    wr(4'h4, 8'h09);
    wait_txn(t0);
    chk("R7 zero count done", txn, t0 + 1);

    // R5 count clamped to buffer size
    for (int i = 0; i < DEPTH; i++) bwr(i, 8'(i * 7 + 3));
    setup_cmd(1'b0, 0, 0, 8'h02, 32'h0, 16'd300);
    push_mosi(8'h02);
    for (int i = 0; i < DEPTH; i++) push_mosi(8'(i * 7 + 3));
    t0 = txn;
    wr(4'h4, 8'h09);
    wait_txn(t0);
    chk("R5 clamped write done", txn, t0 + 1);

    // R2 back to direct, start ignored
    wr(4'h4, 8'h30); rd(4'h4, d); chk("R2 direct again", d, 8'h30);
    wr(4'h4, 8'h01); rd(4'h4, d); chk("R2 direct start ignored", d[1], 1'b0);
    repeat (10) @(negedge clk);
    chk("R2 direct no frame", cs_n, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule